// File: doc/BRIEF.md
# Bridge Fault Latch and Diagnosis Encoder

This block sits between the analog protection comparators of one H-bridge and its output controller. It receives digital flags: a short-circuit flag for the high-side and low-side switch of each output, an over-temperature flag with its temperature-recovered companion, a supply undervoltage flag, an off-state open-load comparator, a current-limit indication and a strobe at the end of each PWM pulse telling whether freewheeling was seen. It filters these flags over a set number of clock cycles and applies a separate latching and clearing rule to each fault class. From them it raises a shutdown request and builds an 8-bit diagnosis byte for the serial interface to return.

Short circuits latch and force shutdown until a clear event arrives. A clear event is the bridge becoming disabled, a diagnosis-reset command, sleep, undervoltage or reset. Over-temperature also latches, but a clear only releases it while the recovered indication is high. Undervoltage is filtered in both directions and does not latch. On-state open load uses two pulse counters, one to set the indication and one to clear it. A direction change clears the current-limit and on-state open-load indications. All filter lengths are parameters counted in clock cycles.

Top module: `bridge_diag`

## Requirements
- R1: A short flag (`hs_short_i[k]` marks a short to ground on output k+1, `ls_short_i[k]` a short to battery) latches only after it has been high together with `blank_i` on SC_FILT consecutive clock edges. The latch is visible one edge later. A shorter run, or a flag raised while `blank_i` is low, latches nothing.
- R2: A latched short holds, with `fault_off_o` high, until one of these clear events: a rising edge of `dis_i`, `diag_clr_i`, `sleep_i`, filtered undervoltage, or reset. A clear event takes effect on the next clock edge.
- R3: Bits 3:0 of the diagnosis byte carry the fault code. Undervoltage gives 0x3 and overrides everything. Otherwise, if any short is latched, the code is 0xF minus an OUT1 term and an OUT2 term. The OUT1 term is 1 for a short to ground and 2 for a short to battery. The OUT2 term is 4 for a short to ground and 8 for a short to battery. A short to ground wins over a short to battery on the same output. With no short, open load gives 0xC and no fault gives 0xF.
- R4: `ot_i` latches over-temperature on the next edge: bit 6 reads 0 and `fault_off_o` is high. A disable edge or `diag_clr_i` releases it only while `temp_ok_i` is high. Sleep, undervoltage and reset release it unconditionally.
- R5: Filtered undervoltage changes state after `uv_i` has differed from it on UV_FILT consecutive edges, and the change is visible one edge later. It applies in both directions and does not latch. While it is set, the code is 0x3, `fault_off_o` is high and all latched faults are cleared.
- R6: While the bridge is enabled, on-state open load sets after OL_CNT consecutive `pwm_end_i` strobes with `fw_seen_i` low. It clears after OL_CNT consecutive strobes with `fw_seen_i` high. Strobes while `dis_i` is high are ignored.
- R7: A change of `dir_i` clears the current-limit indication and the on-state open-load indication on the next edge.
- R8: `cl_i` high while enabled latches current limiting: bit 4 reads 0. It is cleared by a direction change or by any clear event listed in R2.
- R9: Off-state open load reports code 0xC after `ol_off_i` has been high on OL_FILT consecutive edges while `dis_i` is high and `ol_disc_i` is low. The report drops one edge after any of these conditions ends, and `ol_disc_i` high suppresses it.
- R10: The diagnosis byte reads, from bit 7 down: enabled (inverse of `dis_i`, delayed one edge), not-over-temperature, 0, not-current-limit, code. After reset it reads 0xDF.
- R11: `fault_off_o` is high exactly when a short is latched, over-temperature is latched or undervoltage is set. Open load and current limit do not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on) |
| sleep_i | input | 1 | Sleep request; clears all diagnosis state |
| dis_i | input | 1 | Bridge disabled (pin or serial enable, combined) |
| dir_i | input | 1 | Direction level |
| diag_clr_i | input | 1 | Diagnosis-reset command pulse |
| blank_i | input | 1 | Blanking window after a switching transition |
| hs_short_i | input | 2 | High-side short flags, bit k for output k+1 |
| ls_short_i | input | 2 | Low-side short flags, bit k for output k+1 |
| cl_i | input | 1 | Current limitation active |
| ot_i | input | 1 | Over-temperature comparator |
| temp_ok_i | input | 1 | Temperature recovered below switch-on level |
| uv_i | input | 1 | Supply undervoltage comparator |
| ol_off_i | input | 1 | Off-state open-load comparator |
| ol_disc_i | input | 1 | Open-load current source disconnected |
| pwm_end_i | input | 1 | One-cycle strobe at the end of each PWM pulse |
| fw_seen_i | input | 1 | Freewheeling seen in the pulse being strobed |
| diag_o | output | 8 | Diagnosis byte |
| fault_off_o | output | 1 | Shutdown request to output control and error flag |

## Verification
A wrong filter count appears at `diag_o[3:0]` as a code that shows up one edge too early or never appears. The bench checks this by sweeping run lengths just below and at each threshold. A latch that is lost or never cleared appears in both the code and `fault_off_o` on the edge after the clear event. All fifteen combinations of short flags are compared with the arithmetic code rule. A pulse counter that fails to reset on a freewheel strobe or a direction change shows up as open load being reported or cleared one strobe off.

// File: rtl/bdiag_pkg.sv
// Shared codes and the fault-code encoder for the bridge diagnosis block.
// Assumes: gnd/bat vectors are indexed by output (bit 0 = OUT1).
package bdiag_pkg;

    localparam logic [3:0] DIA_NONE = 4'hF;
    localparam logic [3:0] DIA_OPEN = 4'hC;
    localparam logic [3:0] DIA_UNDV = 4'h3;

    // Maps latched shorts, open load and undervoltage to the sparse 4-bit code.
    function automatic logic [3:0] dia_encode(input logic [1:0] gnd,
                                              input logic [1:0] bat,
                                              input logic       open_ld,
                                              input logic       undv);
        logic [1:0] sel1;
        logic [1:0] sel2;
        logic [3:0] code;
        sel1 = gnd[0] ? 2'd1 : (bat[0] ? 2'd2 : 2'd0);
        sel2 = gnd[1] ? 2'd1 : (bat[1] ? 2'd2 : 2'd0);
        case ({sel2, sel1})
            4'b0000: code = open_ld ? DIA_OPEN : DIA_NONE;
            4'b0001: code = 4'hE;
            4'b0010: code = 4'hD;
            4'b0100: code = 4'hB;
            4'b0101: code = 4'hA;
            4'b0110: code = 4'h9;
            4'b1000: code = 4'h7;
            4'b1001: code = 4'h6;
            4'b1010: code = 4'h5;
            default: code = DIA_NONE;
        endcase
        if (undv) code = DIA_UNDV;
        return code;
    endfunction

endpackage

// File: rtl/bdiag_persist.sv
// Consecutive-cycle persistence filter.
// met_o is high once in_i has been high on N consecutive edges and stays
// high while in_i stays high. clr_i restarts the count.
// Assumes: N >= 1.
module bdiag_persist #(
    parameter int N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic in_i,
    output logic met_o
);
    localparam int CW = $clog2(N + 1);

    logic [CW-1:0] cnt;

    // Count consecutive high samples, saturating at N.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i || !in_i) cnt <= '0;
        else if (cnt != CW'(N))       cnt <= cnt + 1'b1;
    end

    assign met_o = (cnt == CW'(N));

    assert_persist_met_R1: assert property (@(posedge clk) disable iff (!rst_n)
        met_o |-> ($past(in_i) && !$past(clr_i)));

endmodule

// File: rtl/bdiag_olon.sv
// On-state open-load detector based on PWM pulses.
// Sets after CNT strobes in a row without freewheeling and clears after CNT
// strobes in a row with freewheeling. clr_i resets both counters and the flag.
// Assumes: pulse_i is already gated to enabled operation.
module bdiag_olon #(
    parameter int CNT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic pulse_i,
    input  logic fw_i,
    output logic ol_o
);
    localparam int CW = $clog2(CNT + 1);

    logic [CW-1:0] miss_cnt;
    logic [CW-1:0] hit_cnt;

    // Track runs of missing and present freewheeling and update the flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            miss_cnt <= '0;
            hit_cnt  <= '0;
            ol_o     <= 1'b0;
        end else if (pulse_i) begin
            if (fw_i) begin
                miss_cnt <= '0;
                if (hit_cnt != CW'(CNT)) hit_cnt <= hit_cnt + 1'b1;
                if (hit_cnt >= CW'(CNT - 1)) ol_o <= 1'b0;
            end else begin
                hit_cnt <= '0;
                if (miss_cnt != CW'(CNT)) miss_cnt <= miss_cnt + 1'b1;
                if (miss_cnt >= CW'(CNT - 1)) ol_o <= 1'b1;
            end
        end
    end

    assert_olon_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ol_o) |-> $past(pulse_i && !fw_i));

    assert_olon_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ol_o) |-> $past(clr_i || (pulse_i && fw_i)));

endmodule

// File: rtl/bridge_diag.sv
// Bridge fault latch and diagnosis encoder (top).
// Filters the digital protection flags of one bridge, latches them by class,
// raises the shutdown request and builds the 8-bit diagnosis byte.
// Assumes: all inputs are synchronous to clk; filter lengths are in cycles.
module bridge_diag
    import bdiag_pkg::*;
#(
    parameter int SC_FILT = 500,
    parameter int UV_FILT = 250,
    parameter int OL_FILT = 10000,
    parameter int OL_CNT  = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_i,
    input  logic       dis_i,
    input  logic       dir_i,
    input  logic       diag_clr_i,
    input  logic       blank_i,
    input  logic [1:0] hs_short_i,
    input  logic [1:0] ls_short_i,
    input  logic       cl_i,
    input  logic       ot_i,
    input  logic       temp_ok_i,
    input  logic       uv_i,
    input  logic       ol_off_i,
    input  logic       ol_disc_i,
    input  logic       pwm_end_i,
    input  logic       fw_seen_i,
    output logic [7:0] diag_o,
    output logic       fault_off_o
);
    localparam int NSC = 4;

    logic           dis_q, dir_q, uv_q, uv_met;
    logic           ot_lat, cl_lat, ol_on, ol_off_hit;
    logic [NSC-1:0] sc_raw, sc_met, sc_lat;
    logic           por_clr, en_clr, evt_clr, dir_chg, short_clr;

    // Bit order: 0 gnd OUT1, 1 gnd OUT2, 2 bat OUT1, 3 bat OUT2.
    assign sc_raw    = {ls_short_i, hs_short_i};
    assign por_clr   = sleep_i | uv_q;
    assign en_clr    = dis_i & ~dis_q;
    assign evt_clr   = en_clr | diag_clr_i;
    assign dir_chg   = dir_i ^ dir_q;
    assign short_clr = por_clr | evt_clr;

    // Remember previous disable and direction levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dis_q <= 1'b0;
            dir_q <= 1'b0;
        end else begin
            dis_q <= dis_i;
            dir_q <= dir_i;
        end
    end

    // Undervoltage: symmetric filter that toggles the state when met.
    bdiag_persist #(.N(UV_FILT)) u_uv_filt (
        .clk(clk), .rst_n(rst_n), .clr_i(uv_met),
        .in_i(uv_i ^ uv_q), .met_o(uv_met)
    );

    // Apply the filtered undervoltage change.
    always_ff @(posedge clk) begin
        if (!rst_n)      uv_q <= 1'b0;
        else if (uv_met) uv_q <= ~uv_q;
    end

    // One filter and latch per short flag.
    for (genvar k = 0; k < NSC; k++) begin : g_short
        bdiag_persist #(.N(SC_FILT)) u_sc_filt (
            .clk(clk), .rst_n(rst_n), .clr_i(short_clr),
            .in_i(sc_raw[k] & blank_i), .met_o(sc_met[k])
        );

        // Latch a confirmed short until a clear event.
        always_ff @(posedge clk) begin
            if (!rst_n || short_clr) sc_lat[k] <= 1'b0;
            else if (sc_met[k])      sc_lat[k] <= 1'b1;
        end

        assert_short_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (sc_lat[k] && !short_clr) |=> sc_lat[k]);
    end

    // Over-temperature latch; released by a clear event only once recovered.
    always_ff @(posedge clk) begin
        if (!rst_n || por_clr)              ot_lat <= 1'b0;
        else if (ot_i)                      ot_lat <= 1'b1;
        else if (evt_clr && temp_ok_i)      ot_lat <= 1'b0;
    end

    // Current-limit indication; cleared by direction change and clear events.
    always_ff @(posedge clk) begin
        if (!rst_n || por_clr || evt_clr || dir_chg) cl_lat <= 1'b0;
        else if (cl_i && !dis_i)                     cl_lat <= 1'b1;
    end

    // On-state open load, counting only while enabled.
    bdiag_olon #(.CNT(OL_CNT)) u_olon (
        .clk(clk), .rst_n(rst_n),
        .clr_i(por_clr | evt_clr | dir_chg | dis_i),
        .pulse_i(pwm_end_i & ~dis_i), .fw_i(fw_seen_i), .ol_o(ol_on)
    );

    // Off-state open load, evaluated only while disabled and sources connected.
    bdiag_persist #(.N(OL_FILT)) u_oloff_filt (
        .clk(clk), .rst_n(rst_n), .clr_i(por_clr),
        .in_i(dis_i & ~ol_disc_i & ol_off_i), .met_o(ol_off_hit)
    );

    assign diag_o = {~dis_q, ~ot_lat, 1'b0, ~cl_lat,
                     dia_encode({sc_lat[1], sc_lat[0]}, {sc_lat[3], sc_lat[2]},
                                ol_on | ol_off_hit, uv_q)};

    assign fault_off_o = (|sc_lat) | ot_lat | uv_q;

    assert_ot_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ot_lat) |-> $past(temp_ok_i || sleep_i || uv_q));

    assert_uv_filtered_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uv_q) |-> $past(uv_i));

    assert_dir_clears_cl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dir_chg |=> diag_o[4]);

endmodule

// File: tb/bridge_diag_bench.sv
module bridge_diag_bench;
    localparam int SC = 3;
    localparam int UV = 2;
    localparam int OLF = 4;
    localparam int OLC = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_i = 0, dis_i = 0, dir_i = 0, diag_clr_i = 0, blank_i = 0;
    logic [1:0] hs_short_i = 0, ls_short_i = 0;
    logic       cl_i = 0, ot_i = 0, temp_ok_i = 0, uv_i = 0;
    logic       ol_off_i = 0, ol_disc_i = 0, pwm_end_i = 0, fw_seen_i = 0;
    logic [7:0] diag_o;
    logic       fault_off_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    bridge_diag #(.SC_FILT(SC), .UV_FILT(UV), .OL_FILT(OLF), .OL_CNT(OLC)) u_bridge_diag (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .dis_i(dis_i), .dir_i(dir_i),
        .diag_clr_i(diag_clr_i), .blank_i(blank_i), .hs_short_i(hs_short_i),
        .ls_short_i(ls_short_i), .cl_i(cl_i), .ot_i(ot_i), .temp_ok_i(temp_ok_i),
        .uv_i(uv_i), .ol_off_i(ol_off_i), .ol_disc_i(ol_disc_i),
        .pwm_end_i(pwm_end_i), .fw_seen_i(fw_seen_i),
        .diag_o(diag_o), .fault_off_o(fault_off_o)
    );

    always #2 clk = ~clk;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Byte from fields: en, over-temp, current-limit, code.
    function automatic logic [7:0] byte_of(input bit en, input bit ot, input bit cl,
                                           input logic [3:0] code);
        return {en, ~ot, 1'b0, ~cl, code};
    endfunction

    // Arithmetic code rule for shorts.
    function automatic logic [3:0] short_code(input bit g1, input bit g2,
                                              input bit b1, input bit b2);
        int v;
        if (!(g1 || g2 || b1 || b2)) return 4'hF;
        v = 15 - (g1 ? 1 : (b1 ? 2 : 0)) - (g2 ? 4 : (b2 ? 8 : 0));
        return 4'(v);
    endfunction

    task automatic spi_clear();
        diag_clr_i = 1; step(1); diag_clr_i = 0;
    endtask

    task automatic pulse(input bit fw);
        pwm_end_i = 1; fw_seen_i = fw; step(1); pwm_end_i = 0; fw_seen_i = 0;
    endtask

    task automatic latch_g1();
        hs_short_i = 2'b01; blank_i = 1; step(SC);
        hs_short_i = 0; blank_i = 0; step(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        step(3); rst_n = 1; step(1);
        chk("R10 reset byte", diag_o, 8'hDF);
        chk("R11 reset shutdown", {7'd0, fault_off_o}, 8'd0);

        // R1: runs shorter than the filter and runs outside blanking.
        for (int w = 1; w < SC; w++) begin
            hs_short_i = 2'b10; blank_i = 1; step(w);
            hs_short_i = 0; blank_i = 0; step(2);
            chk("R1 short run below filter", diag_o, 8'hDF);
        end
        ls_short_i = 2'b01; blank_i = 0; step(SC + 2); ls_short_i = 0; step(1);
        chk("R1 flag outside blanking", diag_o, 8'hDF);

        // R1/R3/R2: every combination of short flags, then serial clear.
        for (int m = 1; m < 16; m++) begin
            hs_short_i = {m[1], m[0]}; ls_short_i = {m[3], m[2]}; blank_i = 1;
            step(SC);
            hs_short_i = 0; ls_short_i = 0; blank_i = 0; step(1);
            chk($sformatf("R3 code for flags %0d", m), diag_o,
                byte_of(1, 0, 0, short_code(m[0], m[1], m[2], m[3])));
            chk("R2 shutdown on short", {7'd0, fault_off_o}, 8'd1);
            spi_clear();
            chk("R2 serial clear", {diag_o[3:0], 3'd0, fault_off_o}, 8'hF0);
        end

        // R2: hold, then clear by disable edge and by sleep.
        latch_g1(); step(10);
        chk("R2 short holds", diag_o, 8'hDE);
        dis_i = 1; step(1);
        chk("R2 disable edge clears, R10 enable bit", diag_o, 8'h5F);
        dis_i = 0; step(1);
        chk("R10 re-enabled", diag_o, 8'hDF);
        ls_short_i = 2'b10; blank_i = 1; step(SC); ls_short_i = 0; blank_i = 0; step(1);
        chk("R3 bat OUT2", diag_o, 8'hD7);
        sleep_i = 1; step(1); sleep_i = 0;
        chk("R2 sleep clears", {diag_o[3:0], 3'd0, fault_off_o}, 8'hF0);

        // R5: undervoltage glitch, set, override and recovery.
        uv_i = 1; step(UV - 1); uv_i = 0; step(3);
        chk("R5 short undervoltage ignored", diag_o, 8'hDF);
        latch_g1();
        uv_i = 1; step(UV + 1);
        chk("R5 undervoltage code", diag_o, 8'hD3);
        chk("R5 R11 undervoltage shutdown", {7'd0, fault_off_o}, 8'd1);
        uv_i = 0; step(UV);
        chk("R5 recovery filtered", diag_o, 8'hD3);
        step(1);
        chk("R5 recovered, short cleared", {diag_o, 7'd0, fault_off_o}, 16'hDF00);

        // R4: over-temperature latch and conditional release.
        ot_i = 1; step(1); ot_i = 0;
        chk("R4 over-temperature byte", diag_o, 8'h9F);
        chk("R4 R11 over-temperature shutdown", {7'd0, fault_off_o}, 8'd1);
        spi_clear();
        chk("R4 clear without recovery held", diag_o, 8'h9F);
        temp_ok_i = 1; spi_clear(); temp_ok_i = 0;
        chk("R4 clear after recovery", {diag_o, 7'd0, fault_off_o}, 16'hDF00);

        // R8/R7: current-limit indication.
        cl_i = 1; step(1); cl_i = 0;
        chk("R8 current limit bit", diag_o, 8'hCF);
        chk("R11 current limit no shutdown", {7'd0, fault_off_o}, 8'd0);
        spi_clear();
        chk("R8 serial clear", diag_o, 8'hDF);
        cl_i = 1; step(1); cl_i = 0;
        dir_i = 1; step(1);
        chk("R7 direction clears current limit", diag_o, 8'hDF);

        // R6: on-state open load set and clear counters.
        for (int i = 0; i < OLC - 1; i++) pulse(0);
        chk("R6 below miss count", diag_o, 8'hDF);
        pulse(0);
        chk("R6 open load set", diag_o, 8'hDC);
        chk("R11 open load no shutdown", {7'd0, fault_off_o}, 8'd0);
        for (int i = 0; i < OLC - 1; i++) pulse(1);
        pulse(0);
        chk("R6 broken freewheel run keeps open load", diag_o, 8'hDC);
        for (int i = 0; i < OLC - 1; i++) pulse(1);
        chk("R6 below hit count", diag_o, 8'hDC);
        pulse(1);
        chk("R6 open load clears", diag_o, 8'hDF);
        for (int i = 0; i < OLC; i++) pulse(0);
        chk("R6 set again", diag_o, 8'hDC);
        dir_i = 0; step(1);
        chk("R7 direction clears open load", diag_o, 8'hDF);
        dis_i = 1; step(1);
        for (int i = 0; i < OLC + 1; i++) pulse(0);
        chk("R6 strobes ignored while disabled", diag_o, 8'h5F);
        dis_i = 0; step(1);

        // R3: short takes priority over open load.
        latch_g1();
        for (int i = 0; i < OLC; i++) pulse(0);
        chk("R3 short over open load", diag_o, 8'hDE);
        spi_clear();
        chk("R3 cleared", diag_o, 8'hDF);

        // R9: off-state open load.
        dis_i = 1; ol_off_i = 1; step(OLF - 1);
        chk("R9 below off filter", diag_o, 8'h5F);
        step(1);
        chk("R9 off-state open load", diag_o, 8'h5C);
        ol_disc_i = 1; step(1);
        chk("R9 suppressed by disconnect", diag_o, 8'h5F);
        ol_disc_i = 0; step(OLF);
        chk("R9 reported again", diag_o, 8'h5C);
        ol_off_i = 0; step(1);
        chk("R9 drops with comparator", diag_o, 8'h5F);
        dis_i = 0; step(1);
        chk("R10 final byte", diag_o, 8'hDF);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule